// File: doc/BRIEF.md
# Sequential Booth Radix-2 Signed Multiplier

This block multiplies two two's-complement operands of width N and returns the full 2N-bit signed product. It takes one clock per multiplier bit and uses one adder/subtractor. One working register holds the partial product in its upper half and the multiplier in its lower half. A single history bit sits below bit 0. Each step looks at the lowest register bit and the history bit. It may add the multiplicand to the upper half or subtract it from the upper half. It then shifts the whole register, including the history bit, right by one place with the sign kept. Because of this recoding, signed operands need no correction before or after the multiply.

A user pulses `start` while the block is idle and holds the operands steady for that cycle. The block raises `busy` for N cycles. It then pulses `done` once and keeps the result on `prod_hi`/`prod_lo` until the next accepted start.

Top module: `booth_seq_mul`

## Requirements
- R1: After reset, `busy` and `done` are 0, and `prod_hi` and `prod_lo` are all zeros.
- R2: A `start` sampled high at a clock edge while `busy` is 0 loads the operands and sets `busy` at that edge. `busy` then stays high for exactly N further edges. `done` goes high at the same edge where `busy` falls, so it is high after edge N+1, counting the load edge as edge 1.
- R3: When `done` is high, {`prod_hi`,`prod_lo`} equals the signed product of the loaded multiplicand and multiplier, taken as a 2N-bit two's-complement value. For N=4, 2 × 7 gives 8'b0000_1110 and 2 × (−3) gives 8'b1111_1010.
- R4: The product is correct when either operand is the most negative N-bit value. For N=4, (−8) × (−8) gives 8'h40 and (−8) × 7 gives 8'hC8.
- R5: `done` is high for exactly one cycle per multiply, and `busy` is 0 whenever `done` is 1.
- R6: A `start` seen while `busy` is 1 is ignored. The running multiply finishes with its own operands, and no extra `done` follows.
- R7: While the block is idle and no start arrives, `prod_hi` and `prod_lo` hold the last result unchanged.
- R8: `prod_hi` carries product bits 2N−1 down to N, and `prod_lo` carries bits N−1 down to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a multiply; taken only when idle |
| mcand | input | N | Signed multiplicand |
| mplier | input | N | Signed multiplier |
| busy | output | 1 | High while the steps run |
| done | output | 1 | One-cycle pulse when the product is ready |
| prod_hi | output | N | Upper half of the product |
| prod_lo | output | N | Lower half of the product |

## Verification
The bench drives `start` on a falling edge, so the load happens at the next rising edge. It expects `busy` to be high at the following falling edge. It expects `done` at the falling edge N+1 clocks after the one where `start` was driven. The driver counts falling edges to confirm that exact distance. A separate monitor compares the product against the queued expectation only in the cycle where `done` is seen. After each result, the driver waits N+2 more idle cycles. It checks that the product is still held and that no stray `done` appears. Starts injected during a run must leave both the result and the pulse count unchanged.

// File: rtl/booth_pkg.sv
package booth_pkg;
    typedef enum logic [1:0] {
        BOP_HOLD = 2'd0,
        BOP_ADD  = 2'd1,
        BOP_SUB  = 2'd2
    } booth_op_e;
endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
    import booth_pkg::*;
(
    input  logic      cur_bit,
    input  logic      prev_bit,
    output booth_op_e op
);
    always_comb begin
        unique case ({cur_bit, prev_bit})
            2'b01:   op = BOP_ADD;   // a run of ones has just ended
            2'b10:   op = BOP_SUB;   // a run of ones is starting
            default: op = BOP_HOLD;  // inside a run of ones or zeros
        endcase
    end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
    import booth_pkg::*;
#(
    parameter int W = 33
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  booth_op_e    op,
    output logic [W-1:0] y
);
    logic          sub;
    logic [W-1:0]  b_gated;

    always_comb begin
        sub     = (op == BOP_SUB);
        b_gated = (op == BOP_HOLD) ? '0 : (b ^ {W{sub}});
        y       = a + b_gated + W'(sub);
    end
endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul
    import booth_pkg::*;
#(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [N-1:0] mcand,
    input  logic [N-1:0] mplier,
    output logic         busy,
    output logic         done,
    output logic [N-1:0] prod_hi,
    output logic [N-1:0] prod_lo
);
    localparam int CW = $clog2(N + 1);
    localparam int AW = N + 1;

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [N-1:0]  hi;
        logic [N-1:0]  lo;
        logic          xb;
        logic [CW-1:0] cnt;
        logic [N-1:0]  mc;
    } mul_state_t;

    mul_state_t st_q, st_d;
    booth_op_e  op_d;
    logic [AW-1:0] acc_d;

    booth_recoder u_rec (
        .cur_bit  (st_q.lo[0]),
        .prev_bit (st_q.xb),
        .op       (op_d)
    );

    // the extra top bit keeps the most negative multiplicand exact
    booth_addsub #(.W(AW)) u_addsub (
        .a  ({st_q.hi[N-1], st_q.hi}),
        .b  ({st_q.mc[N-1], st_q.mc}),
        .op (op_d),
        .y  (acc_d)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.hi   = '0;
                st_d.lo   = mplier;
                st_d.xb   = 1'b0;
                st_d.mc   = mcand;
                st_d.cnt  = CW'(N);
            end
        end else begin
            st_d.hi  = acc_d[AW-1:1];
            st_d.lo  = {acc_d[0], st_q.lo[N-1:1]};
            st_d.xb  = st_q.lo[0];
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == CW'(1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = st_q.busy;
    assign done    = st_q.done;
    assign prod_hi = st_q.hi;
    assign prod_lo = st_q.lo;
endmodule

// File: rtl/booth_seq_mul_chk.sv
module booth_seq_mul_chk #(
    parameter int N = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [N-1:0] mcand,
    input logic [N-1:0] mplier,
    input logic         busy,
    input logic         done,
    input logic [N-1:0] prod_hi,
    input logic [N-1:0] prod_lo
);
    logic [N-1:0]   cap_a, cap_b;
    logic [2*N-1:0] model_p;
    int unsigned    steps;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_a <= '0;
            cap_b <= '0;
            steps <= 0;
        end else if (start && !busy) begin
            cap_a <= mcand;
            cap_b <= mplier;
            steps <= 0;
        end else if (busy) begin
            steps <= steps + 1;
        end
    end

    always_comb begin
        model_p = (2*N)'($signed({{N{cap_a[N-1]}}, cap_a}) * $signed({{N{cap_b[N-1]}}, cap_b}));
    end

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (steps == N));
    assert_fall_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    assert_product_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ({prod_hi, prod_lo} == model_p));
    assert_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_idle_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(prod_hi) && $stable(prod_lo)));
endmodule

bind booth_seq_mul booth_seq_mul_chk #(.N(N)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .mcand   (mcand),
    .mplier  (mplier),
    .busy    (busy),
    .done    (done),
    .prod_hi (prod_hi),
    .prod_lo (prod_lo)
);

// File: tb/booth_seq_mul_tb_top.sv
`timescale 1ns/1ps
module booth_seq_mul_tb_top;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [N-1:0] mcand = '0;
    logic [N-1:0] mplier = '0;
    logic         busy, done;
    logic [N-1:0] prod_hi, prod_lo;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [2*N-1:0] expq[$];
    logic prev_done = 1'b0;

    always #2.5 clk = ~clk;

    booth_seq_mul #(.N(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand), .mplier(mplier),
        .busy(busy), .done(done), .prod_hi(prod_hi), .prod_lo(prod_lo)
    );

    function automatic logic [2*N-1:0] ref_mul(logic [N-1:0] a, logic [N-1:0] b);
        return (2*N)'($signed({{N{a[N-1]}}, a}) * $signed({{N{b[N-1]}}, b}));
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every done pulse
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (done) begin
                chk(!busy, "R5 busy low with done", 32'(busy), 0);
                chk(!prev_done, "R5 single-cycle done", 32'(prev_done), 0);
                if (expq.size() == 0) begin
                    chk(0, "R6 unexpected done", 1, 0);
                end else begin
                    logic [2*N-1:0] e;
                    e = expq.pop_front();
                    chk({prod_hi, prod_lo} == e, "R3 product", 32'({prod_hi, prod_lo}), 32'(e));
                    chk(prod_hi == e[2*N-1:N], "R8 high word", 32'(prod_hi), 32'(e[2*N-1:N]));
                    chk(prod_lo == e[N-1:0], "R8 low word", 32'(prod_lo), 32'(e[N-1:0]));
                end
            end
            prev_done = done;
        end
    end

    // driver: pushes the expectation and runs one multiply
    task automatic run_mul(logic [N-1:0] a, logic [N-1:0] b, bit inject, string tag);
        logic [2*N-1:0] e;
        int c;
        e = ref_mul(a, b);
        expq.push_back(e);
        @(negedge clk);
        start = 1'b1; mcand = a; mplier = b;
        @(negedge clk);
        start = 1'b0; mcand = ~a; mplier = ~b;
        c = 1;
        chk(busy == 1'b1, "R2 busy after accept", 32'(busy), 1);
        while (!done && c < 4*N) begin
            @(negedge clk);
            c++;
            if (inject && c == 3) begin start = 1'b1; mcand = b; mplier = a + 1'b1; end
            if (inject && c == 4) start = 1'b0;
        end
        chk(c == N + 1, {"R2 latency ", tag}, 32'(c), 32'(N + 1));
        for (int k = 0; k < N + 2; k++) @(negedge clk);
        chk({prod_hi, prod_lo} == e, {"R7 result held ", tag}, 32'({prod_hi, prod_lo}), 32'(e));
        if (inject) chk(!busy, "R6 no restart from busy start", 32'(busy), 0);
    endtask

    initial begin
        #(200000 * 5);
        chk(0, "watchdog expired", 0, 1);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done, "R1 reset flags", 32'({busy, done}), 0);
        chk({prod_hi, prod_lo} == '0, "R1 reset product", 32'({prod_hi, prod_lo}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_mul(4'd2, 4'd7, 0, "R3 2x7");
        run_mul(4'd2, 4'hD, 0, "R3 2x-3");
        run_mul(4'h8, 4'h8, 0, "R4 -8x-8");
        run_mul(4'h8, 4'h7, 0, "R4 -8x7");
        run_mul(4'h7, 4'h8, 0, "R4 7x-8");
        run_mul(4'h5, 4'h6, 1, "R6 start while busy");
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                run_mul(4'(a), 4'(b), (a + b) % 5 == 0, "R3 sweep");
        repeat (4) @(negedge clk);
        chk(expq.size() == 0, "R6 all results delivered", 32'(expq.size()), 0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule